// File: doc/BRIEF.md
# Brown-out and Power-on Reset Sequencer

This block decides when a chip may leave reset after power is applied, after a brown-out, and after a resume from power-down. It first waits a fixed number of cycles while the core supply regulator settles. It then waits for several conditions that run in parallel: a count of oscillator-running edges, PLL lock, and a programmable power-up delay. The configured clock source decides which of these conditions apply. Internal reset is released, and code may execute, only when every applicable condition has been met.

The system clock is gated separately from reset. The clock enable rises as soon as the oscillator and PLL conditions are met, which can be before the power-up delay has expired. A sticky status flag records that a brown-out has occurred. Software clears it by writing zero.

The analog comparators, the regulator and the oscillators are outside the block. They appear here only as digital inputs that are synchronous to `clk`, except `osc_run`, which is synchronized inside the block.

Top module: `bor_por_seq`

## Requirements
- R1: While `por_n` is low, `sys_rst`=1, `clk_en`=0, `exec_en`=0 and `bor_stat`=0.
- R2: After a start event (rise of `por_n`, or the fall of `bor_flag` or of a `resume` pulse), a regulator wait of REG_CYC cycles runs. When no other condition applies, `sys_rst` falls after exactly REG_CYC+1 rising edges. `exec_en` always equals the inverse of `sys_rst`.
- R3: Clock-source decoding works as follows. `osc_sel` values 1 and 3 use the PLL. A crystal is in use only when `osc_sel` is 2 or 3 and `posc_mode` is 1 or 2. Every other combination needs no oscillator start-up count.
- R4: When a crystal is in use, `clk_en` stays 0 and reset stays held until OST_EDGES rising edges of `osc_run` have been counted after the regulator wait. `osc_run` passes through a two-flop synchronizer before counting.
- R5: When the PLL is used, `clk_en` and reset release wait for `pll_lock`=1. A drop of `pll_lock` before release takes `clk_en` back to 0 and holds reset.
- R6: `pwrt_sel`=k, with k from 1 to 7, gives a power-up delay of (2^k)·CYC_PER_MS cycles that runs concurrently with the other waits. Reset then falls after REG_CYC+1+delay edges.
- R7: When `pwrt_sel`=0 and a crystal is in use, the power-up delay is replaced by FSCM_CYC cycles. When `pwrt_sel`=0 and no crystal is in use, the power-up delay is zero.
- R8: `bor_flag`=1 in any state, including after release, asserts `sys_rst` and sets `bor_stat` on the next edge. It restarts the whole sequence from the regulator wait.
- R9: `bor_stat` is cleared only by `stat_wr` with `stat_wdata`=0, or by `por_n`. Writing 1 has no effect. A brown-out in the same cycle as a clearing write wins.
- R10: A one-cycle `resume` pulse restarts the whole sequence. It leaves `bor_stat` unchanged.
- R11: Once reset has been released, a loss of `pll_lock` has no effect: `sys_rst` stays 0 and `clk_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bor_flag | input | 1 | Brown-out comparator output, synchronous |
| resume | input | 1 | Pulse marking a resume from power-down |
| osc_sel | input | 3 | Clock-source select |
| posc_mode | input | 2 | Primary oscillator mode |
| pwrt_sel | input | 3 | Power-up delay select |
| osc_run | input | 1 | Oscillator activity, asynchronous |
| pll_lock | input | 1 | PLL lock indication |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Status write value |
| sys_rst | output | 1 | Internal system reset, active high |
| clk_en | output | 1 | System clock enable (0 = clock held) |
| exec_en | output | 1 | Code execution enable |
| bor_stat | output | 1 | Sticky brown-out status |

## Verification
The bench builds the block with REG_CYC=5, OST_EDGES=8, CYC_PER_MS=4 and FSCM_CYC=20. These values keep even the longest power-up setting (512 cycles) short, so every `pwrt_sel` code and the crystal fail-safe delay can be timed to the exact edge. A start-up count of only eight `osc_run` edges lets the bench stop one edge short of release and then finish it. The small regulator wait leaves room to land brown-outs and resume pulses in both the waiting phase and the released phase.

// File: rtl/bor_por_seq.sv
module bor_por_seq #(
  parameter int REG_CYC    = 160,
  parameter int OST_EDGES  = 1024,
  parameter int CYC_PER_MS = 8000,
  parameter int FSCM_CYC   = 800
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       bor_flag,
  input  logic       resume,
  input  logic [2:0] osc_sel,
  input  logic [1:0] posc_mode,
  input  logic [2:0] pwrt_sel,
  input  logic       osc_run,
  input  logic       pll_lock,
  input  logic       stat_wr,
  input  logic       stat_wdata,
  output logic       sys_rst,
  output logic       clk_en,
  output logic       exec_en,
  output logic       bor_stat
);
  localparam int PW_MAX = CYC_PER_MS * 128;
  localparam int BIG0   = (PW_MAX > FSCM_CYC) ? PW_MAX : FSCM_CYC;
  localparam int BIG    = (BIG0 > REG_CYC) ? BIG0 : REG_CYC;
  localparam int TW     = $clog2(BIG + 1) + 1;
  localparam int OW     = $clog2(OST_EDGES + 1);

  typedef enum logic [1:0] {S_REG, S_RUN, S_DONE} st_t;
  st_t st;

  logic [TW-1:0] tmr;
  logic [OW-1:0] ost_cnt;
  logic [2:0]    run_sync;

  wire crystal  = (osc_sel == 3'd2 || osc_sel == 3'd3) && (posc_mode == 2'd1 || posc_mode == 2'd2);
  wire pll_need = (osc_sel == 3'd1 || osc_sel == 3'd3);
  wire run_edge = run_sync[1] & ~run_sync[2];

  wire [TW-1:0] pwrt_target = (pwrt_sel == 3'd0) ? (crystal ? TW'(FSCM_CYC) : '0)
                                                 : (TW'(CYC_PER_MS) << pwrt_sel);
  wire pwrt_done = (tmr >= pwrt_target);
  wire ost_ok    = !crystal || (ost_cnt == OW'(OST_EDGES));
  wire pll_ok    = !pll_need || pll_lock;
  wire release_now = (st == S_RUN) && ost_ok && pll_ok && pwrt_done;

  assign sys_rst = (st != S_DONE);
  assign exec_en = (st == S_DONE);
  assign clk_en  = (st == S_DONE) || ((st == S_RUN) && ost_ok && pll_ok);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_sync <= '0;
    else        run_sync <= {run_sync[1:0], osc_run};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= S_REG;
      tmr     <= '0;
      ost_cnt <= '0;
    end else if (bor_flag || resume) begin
      st      <= S_REG;
      tmr     <= '0;
      ost_cnt <= '0;
    end else begin
      case (st)
        S_REG: begin
          ost_cnt <= '0;
          if (tmr == TW'(REG_CYC - 1)) begin
            st  <= S_RUN;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_RUN: begin
          if (release_now) st <= S_DONE;
          if (!pwrt_done) tmr <= tmr + 1'b1;
          if (run_edge && ost_cnt != OW'(OST_EDGES)) ost_cnt <= ost_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     bor_stat <= 1'b0;
    else if (bor_flag)              bor_stat <= 1'b1;
    else if (stat_wr && !stat_wdata) bor_stat <= 1'b0;
  end

  AST_BOR_RESETS: assert property (@(posedge clk) disable iff (!por_n)
    bor_flag |=> (bor_stat && sys_rst)); // R8
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (bor_stat && !(stat_wr && !stat_wdata)) |=> bor_stat); // R9
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (stat_wr && !stat_wdata && !bor_flag) |=> !bor_stat); // R9
  AST_RELEASE_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (!$past(pll_need) || $past(pll_lock))); // R5
  AST_STAY_RELEASED: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !bor_flag && !resume) |=> (!sys_rst && clk_en)); // R11
  AST_EXEC_MATCH: assert property (@(posedge clk) disable iff (!por_n)
    exec_en != sys_rst); // R2
endmodule

// File: tb/bor_por_seq_bench.sv
`timescale 1ns/1ps
module bor_por_seq_bench;
  localparam int REG = 5, OSTN = 8, CPM = 4, FS = 20, LIM = 700;

  logic clk = 0, por_n = 0, bor_flag = 0, resume = 0;
  logic [2:0] osc_sel = 0, pwrt_sel = 0;
  logic [1:0] posc_mode = 0;
  logic osc_run = 0, pll_lock = 0, stat_wr = 0, stat_wdata = 0;
  logic sys_rst, clk_en, exec_en, bor_stat;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bor_por_seq #(.REG_CYC(REG), .OST_EDGES(OSTN), .CYC_PER_MS(CPM), .FSCM_CYC(FS)) u_bor_por_seq (
    .clk(clk), .por_n(por_n), .bor_flag(bor_flag), .resume(resume),
    .osc_sel(osc_sel), .posc_mode(posc_mode), .pwrt_sel(pwrt_sel),
    .osc_run(osc_run), .pll_lock(pll_lock), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .sys_rst(sys_rst), .clk_en(clk_en), .exec_en(exec_en), .bor_stat(bor_stat));

  // {osc_sel, posc_mode, pwrt_sel}
  localparam logic [7:0] VEC [9] = '{
    {3'd0,2'd0,3'd0}, {3'd0,2'd0,3'd1}, {3'd1,2'd0,3'd2}, {3'd4,2'd0,3'd3},
    {3'd2,2'd0,3'd7}, {3'd3,2'd0,3'd0}, {3'd2,2'd1,3'd0}, {3'd3,2'd2,3'd5},
    {3'd2,2'd3,3'd4}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_xtal(logic [2:0] s, logic [1:0] p);
    return (s == 2 || s == 3) && (p == 1 || p == 2);
  endfunction

  function automatic int dly(logic [2:0] s, logic [1:0] p, logic [2:0] w);
    if (w != 0) return CPM << w;
    return is_xtal(s, p) ? FS : 0;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por_start(logic [2:0] s, logic [1:0] p, logic [2:0] w);
    @(negedge clk);
    por_n = 0; osc_sel = s; posc_mode = p; pwrt_sel = w;
    cyc(2);
    por_n = 1;
  endtask

  task automatic meas(output int n);
    n = 0;
    while (sys_rst && n < LIM) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic osc_edges(int n);
    repeat (n) begin
      osc_run = 1; cyc(2); osc_run = 0; cyc(2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    // R1 reset state
    chk("R1 sys_rst", sys_rst, 1);
    chk("R1 clk_en", clk_en, 0);
    chk("R1 exec_en", exec_en, 0);
    chk("R1 bor_stat", bor_stat, 0);

    // table walk: R2 R3 R6 R7 (pll locked, oscillator silent)
    pll_lock = 1;
    for (int i = 0; i < 9; i++) begin
      logic [2:0] s; logic [1:0] p; logic [2:0] w;
      {s, p, w} = VEC[i];
      por_start(s, p, w);
      meas(n);
      if (!is_xtal(s, p)) begin
        chk($sformatf("R6 R7 R2 release edge vec%0d", i), n, REG + 1 + dly(s, p, w));
        chk("R2 exec_en", exec_en, 1);
        chk("R3 clk_en no ost", clk_en, 1);
      end else begin
        chk($sformatf("R3 R4 crystal held vec%0d", i), sys_rst, 1);
        chk("R4 clk held", clk_en, 0);
      end
    end

    // R4 oscillator start-up count, one edge short then complete
    por_start(3'd2, 2'd1, 3'd0);
    cyc(REG + 3);
    osc_edges(OSTN - 1);
    cyc(4);
    chk("R4 short count rst", sys_rst, 1);
    chk("R4 short count clk", clk_en, 0);
    osc_edges(1);
    cyc(6);
    chk("R4 full count clk", clk_en, 1);
    chk("R4 R7 full count rst", sys_rst, 0);

    // R5 PLL wait
    pll_lock = 0;
    por_start(3'd1, 2'd0, 3'd1);
    cyc(40);
    chk("R5 no lock rst", sys_rst, 1);
    chk("R5 no lock clk", clk_en, 0);
    pll_lock = 1;
    cyc(1);
    chk("R5 lock clk", clk_en, 1);
    chk("R5 lock rst", sys_rst, 0);

    // R5 lock drop before release, R11 after release
    por_start(3'd1, 2'd0, 3'd7);
    cyc(REG + 5);
    chk("R5 clk before drop", clk_en, 1);
    pll_lock = 0;
    cyc(1);
    chk("R5 clk after drop", clk_en, 0);
    pll_lock = 1;
    meas(n);
    chk("R5 released after relock", sys_rst, 0);
    pll_lock = 0;
    cyc(10);
    chk("R11 rst after lock loss", sys_rst, 0);
    chk("R11 clk after lock loss", clk_en, 1);
    pll_lock = 1;

    // R8 brown-out after release
    por_start(3'd0, 2'd0, 3'd1);
    meas(n);
    chk("R8 pre bor stat", bor_stat, 0);
    bor_flag = 1;
    cyc(1);
    chk("R8 bor rst", sys_rst, 1);
    chk("R8 bor stat", bor_stat, 1);
    chk("R8 bor clk", clk_en, 0);
    cyc(2);
    bor_flag = 0;
    meas(n);
    chk("R8 restart timing", n, REG + 1 + 8);

    // R9 status write behaviour
    stat_wr = 1; stat_wdata = 1; cyc(1); stat_wr = 0;
    cyc(1);
    chk("R9 write one ignored", bor_stat, 1);
    stat_wr = 1; stat_wdata = 0; bor_flag = 1; cyc(1); stat_wr = 0; bor_flag = 0;
    cyc(1);
    chk("R9 bor wins clear", bor_stat, 1);
    meas(n);
    stat_wr = 1; stat_wdata = 0; cyc(1); stat_wr = 0;
    cyc(1);
    chk("R9 clear", bor_stat, 0);

    // R8 brown-out during power-up delay restarts
    por_start(3'd0, 2'd0, 3'd7);
    cyc(100);
    bor_flag = 1; cyc(1); bor_flag = 0;
    meas(n);
    chk("R8 bor mid-sequence timing", n, REG + 1 + 512);

    // R10 resume restarts without touching status
    stat_wr = 1; stat_wdata = 0; cyc(1); stat_wr = 0;
    pwrt_sel = 3'd2;
    resume = 1; cyc(1); resume = 0;
    chk("R10 resume rst", sys_rst, 1);
    chk("R10 resume stat", bor_stat, 0);
    meas(n);
    chk("R10 resume timing", n, REG + 1 + 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule